// File: doc/BRIEF.md
# Writable Branch Metric Table for a Four-State Equalizer Trellis

This block supplies the branch metrics that a four-state sequence equalizer needs at each sample. A quantized receiver sample arrives with a valid strobe. The block reads one row of a small on-chip table, selected by that sample value, and registers the row as eight metrics, one for each trellis branch. The table is built from flops and can be written at any time through a simple write port. Control software can therefore retune the metrics during live decoding, for instance to follow channel distortion that drifts slowly. The block does not compute the metric values; whoever writes the table provides them.

Each branch is identified by its index b = {previous state, new input bit}. The state it leads to is {previous state[0], input bit}. Metric lane b of the output carries the table entry for branch b.

Top module: `bm_table_unit`

## Requirements
- R1: While `rst_n` is low, and on the first clock after it, `bm_vld_o` is 0 and every bit of `bm_o` is 0.
- R2: After reset every table entry reads as 0 until it is written.
- R3: A write with `wr_en_i` high stores `wr_data_i` at the entry addressed by `wr_addr_i`. Bits [5:3] of the address are the sample value and bits [2:0] are the branch index. No other entry changes.
- R4: When `smp_vld_i` is high at a clock edge, the metrics for that sample appear on `bm_o` after that edge, and `bm_vld_o` is high for exactly that cycle. When `smp_vld_i` is low at an edge, `bm_vld_o` is low after it.
- R5: Lane b of `bm_o` (bits b*6+5 down to b*6) holds the metric of branch b. Here b = {previous state[1:0], input bit}, and the branch leads to state {previous state[0], input bit}.
- R6: If a write and a read of the same entry happen at the same edge, the read returns the old value. The next read returns the new value.
- R7: When `smp_vld_i` is low at an edge, `bm_o` keeps its previous value.
- R8: Address and data presented with `wr_en_i` low change no table entry.
- R9: Writes made while samples stream through leave the metrics read from other entries unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_i | input | 3 | Quantized receiver sample |
| smp_vld_i | input | 1 | Sample valid strobe |
| wr_en_i | input | 1 | Table write enable |
| wr_addr_i | input | 6 | Write address {sample value, branch index} |
| wr_data_i | input | 6 | Metric value to store |
| bm_o | output | 48 | Eight registered 6-bit branch metrics, lane b at bits b*6 +: 6 |
| bm_vld_o | output | 1 | High the cycle after an accepted sample |

## Verification
On every cycle, assertions check four things. The valid flag follows the strobe by one cycle. The metric bus stays still after an edge with no strobe. Each write decodes to exactly one row and one branch, and nothing is decoded when the write enable is low. A table row does not change in a cycle in which it is not selected for writing. Some behaviours need a model of the table contents, so only the bench scenarios can show them. These are the read-old-on-collision rule, the address field split, the placement of lanes by branch index, the zero state after reset, and the isolation of entries during streaming writes.

// File: rtl/bmt_pkg.sv
package bmt_pkg;
   // Default geometry of the metric table
   localparam int unsigned DEF_SMP_W   = 3;  // sample resolution
   localparam int unsigned DEF_MET_W   = 6;  // metric resolution
   localparam int unsigned DEF_ST_BITS = 2;  // trellis state bits (four states)

   // Number of trellis branches for a given state width
   function automatic int unsigned branch_count(int unsigned st_bits);
      return 1 << (st_bits + 1);
   endfunction

   // Number of distinct sample codes
   function automatic int unsigned sample_count(int unsigned smp_w);
      return 1 << smp_w;
   endfunction
endpackage

// File: rtl/bmt_wr_decode.sv
module bmt_wr_decode #(
   parameter int unsigned SMP_W = bmt_pkg::DEF_SMP_W,
   parameter int unsigned BR_W  = bmt_pkg::DEF_ST_BITS + 1,
   localparam int unsigned AW   = SMP_W + BR_W,
   localparam int unsigned NS   = 1 << SMP_W,
   localparam int unsigned NB   = 1 << BR_W
) (
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   output logic [NS-1:0] row_we,
   output logic [NB-1:0] br_sel
);
   logic [SMP_W-1:0] row_idx;
   logic [BR_W-1:0]  br_idx;

   assign row_idx = wr_addr[AW-1:BR_W];
   assign br_idx  = wr_addr[BR_W-1:0];

   // Row strobe only when writing; branch select is a plain one-hot decode
   always_comb begin
      row_we = '0;
      if (wr_en) row_we[row_idx] = 1'b1;
   end

   always_comb begin
      br_sel = '0;
      br_sel[br_idx] = 1'b1;
   end
endmodule

// File: rtl/bmt_row.sv
module bmt_row #(
   parameter int unsigned NB    = bmt_pkg::branch_count(bmt_pkg::DEF_ST_BITS),
   parameter int unsigned MET_W = bmt_pkg::DEF_MET_W,
   localparam int unsigned ROW_W = NB * MET_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             row_we,
   input  logic [NB-1:0]    br_sel,
   input  logic [MET_W-1:0] wr_data,
   output logic [ROW_W-1:0] row_q
);
   // One register per branch entry of this sample row
   for (genvar b = 0; b < NB; b++) begin : g_entry
      always_ff @(posedge clk) begin
         if (!rst_n)
            row_q[b*MET_W +: MET_W] <= '0;
         else if (row_we && br_sel[b])
            row_q[b*MET_W +: MET_W] <= wr_data;
      end
   end

   // Unselected rows keep their content
   assert_row_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !row_we |=> $stable(row_q))
      else $error("row changed without a write strobe");
endmodule

// File: rtl/bmt_read_stage.sv
module bmt_read_stage #(
   parameter int unsigned SMP_W = bmt_pkg::DEF_SMP_W,
   parameter int unsigned ROW_W = bmt_pkg::branch_count(bmt_pkg::DEF_ST_BITS) * bmt_pkg::DEF_MET_W,
   localparam int unsigned NS   = 1 << SMP_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NS*ROW_W-1:0] rows,
   input  logic [SMP_W-1:0]   smp,
   input  logic               smp_vld,
   output logic [ROW_W-1:0]   bm_q,
   output logic               bm_vld_q
);
   logic [ROW_W-1:0] row_mux;

   // Row select by sample value, built as an AND-OR tree over all rows
   always_comb begin
      row_mux = '0;
      for (int s = 0; s < int'(NS); s++) begin
         if (smp == SMP_W'(s)) row_mux = row_mux | rows[s*ROW_W +: ROW_W];
      end
   end

   // Output captures pre-edge table contents, so a same-edge write is not seen
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bm_q     <= '0;
         bm_vld_q <= 1'b0;
      end else begin
         bm_vld_q <= smp_vld;
         if (smp_vld) bm_q <= row_mux;
      end
   end

   assert_vld_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      smp_vld |=> bm_vld_q)
      else $error("valid flag missed an accepted sample");

   assert_vld_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_vld |=> !bm_vld_q)
      else $error("valid flag raised without a sample");

   assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_vld |=> $stable(bm_q))
      else $error("metrics changed without a sample");
endmodule

// File: rtl/bm_table_unit.sv
module bm_table_unit #(
   parameter int unsigned SMP_W   = bmt_pkg::DEF_SMP_W,
   parameter int unsigned MET_W   = bmt_pkg::DEF_MET_W,
   parameter int unsigned ST_BITS = bmt_pkg::DEF_ST_BITS,
   localparam int unsigned BR_W   = ST_BITS + 1,
   localparam int unsigned NB     = bmt_pkg::branch_count(ST_BITS),
   localparam int unsigned NS     = bmt_pkg::sample_count(SMP_W),
   localparam int unsigned AW     = SMP_W + BR_W,
   localparam int unsigned ROW_W  = NB * MET_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SMP_W-1:0] smp_i,
   input  logic             smp_vld_i,
   input  logic             wr_en_i,
   input  logic [AW-1:0]    wr_addr_i,
   input  logic [MET_W-1:0] wr_data_i,
   output logic [ROW_W-1:0] bm_o,
   output logic             bm_vld_o
);
   // Elaboration-time sanity of the geometry
   if (SMP_W < 1 || SMP_W > 8) begin : g_bad_smp
      $error("SMP_W out of supported range");
   end
   if (MET_W < 1 || MET_W > 16) begin : g_bad_met
      $error("MET_W out of supported range");
   end
   if (ST_BITS < 1 || ST_BITS > 6) begin : g_bad_st
      $error("ST_BITS out of supported range");
   end
   if (NS * NB > 4096) begin : g_bad_size
      $error("table too large");
   end

   logic [NS-1:0]       row_we;
   logic [NB-1:0]       br_sel;
   logic [NS*ROW_W-1:0] rows;

   bmt_wr_decode #(.SMP_W(SMP_W), .BR_W(BR_W)) u_dec (
      .wr_en  (wr_en_i),
      .wr_addr(wr_addr_i),
      .row_we (row_we),
      .br_sel (br_sel)
   );

   // One storage row per sample code
   for (genvar s = 0; s < NS; s++) begin : g_row
      bmt_row #(.NB(NB), .MET_W(MET_W)) u_row (
         .clk    (clk),
         .rst_n  (rst_n),
         .row_we (row_we[s]),
         .br_sel (br_sel),
         .wr_data(wr_data_i),
         .row_q  (rows[s*ROW_W +: ROW_W])
      );
   end

   bmt_read_stage #(.SMP_W(SMP_W), .ROW_W(ROW_W)) u_rd (
      .clk     (clk),
      .rst_n   (rst_n),
      .rows    (rows),
      .smp     (smp_i),
      .smp_vld (smp_vld_i),
      .bm_q    (bm_o),
      .bm_vld_q(bm_vld_o)
   );

   assert_wr_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i |-> ($countones(row_we) == 1 && $countones(br_sel) == 1))
      else $error("write did not decode to a single entry");

   assert_no_wr_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en_i |-> (row_we == '0))
      else $error("row strobe without write enable");
endmodule

// File: tb/bm_table_unit_bench.sv
module bm_table_unit_bench;
   localparam int SW = 3, MW = 6, NB = 8, NS = 8, RW = NB * MW;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [SW-1:0] smp_i;
   logic          smp_vld_i;
   logic          wr_en_i;
   logic [5:0]    wr_addr_i;
   logic [MW-1:0] wr_data_i;
   logic [RW-1:0] bm_o;
   logic          bm_vld_o;

   int n_run = 0, n_fail = 0;
   bit done = 0;

   logic [MW-1:0] mdl [NS*NB];
   logic [RW-1:0] exp_bm;
   logic          exp_vld;

   always #5 clk = ~clk;

   bm_table_unit u_bm_table_unit (
      .clk(clk), .rst_n(rst_n), .smp_i(smp_i), .smp_vld_i(smp_vld_i),
      .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
      .bm_o(bm_o), .bm_vld_o(bm_vld_o)
   );

   // Vector fields: {we, addr[5:0], data[5:0], vld, smp[2:0]}
   localparam int NV = 13;
   localparam logic [16:0] VEC [NV] = '{
      {1'b0, 6'd0,  6'h00, 1'b1, 3'd3},  // plain read
      {1'b1, 6'd29, 6'h2A, 1'b1, 3'd3},  // R6 collision: old value
      {1'b0, 6'd0,  6'h00, 1'b1, 3'd3},  // new value visible
      {1'b0, 6'd29, 6'h11, 1'b0, 3'd3},  // R8 disabled write, R7 hold
      {1'b0, 6'd0,  6'h00, 1'b1, 3'd3},  // still 0x2A
      {1'b1, 6'd48, 6'h3F, 1'b1, 3'd1},  // R9 write row 6 while reading row 1
      {1'b0, 6'd0,  6'h00, 1'b1, 3'd6},
      {1'b0, 6'd0,  6'h00, 1'b1, 3'd1},
      {1'b1, 6'd7,  6'h05, 1'b0, 3'd2},  // write, no read: hold
      {1'b0, 6'd0,  6'h00, 1'b1, 3'd0},
      {1'b0, 6'd0,  6'h00, 1'b1, 3'd7},
      {1'b1, 6'd63, 6'h00, 1'b1, 3'd7},  // collision again
      {1'b0, 6'd0,  6'h00, 1'b1, 3'd7}
   };

   function automatic logic [MW-1:0] fill(int s, int b);
      return MW'(((s * NB + b) * 5 + 3) % 64);
   endfunction

   task automatic check(string req, logic [RW-1:0] act, logic [RW-1:0] exp,
                        logic av, logic ev);
      n_run++;
      if (act !== exp || av !== ev) begin
         n_fail++;
         $display("FAIL %s: bm=%h vld=%b expected bm=%h vld=%b", req, act, av, exp, ev);
      end
   endtask

   // One clock: drive at negedge, update model at posedge, sample 1 ns later
   task automatic step(logic we, logic [5:0] ad, logic [MW-1:0] d, logic v, logic [SW-1:0] s);
      @(negedge clk);
      wr_en_i = we; wr_addr_i = ad; wr_data_i = d; smp_vld_i = v; smp_i = s;
      @(posedge clk);
      if (v) for (int b = 0; b < NB; b++) exp_bm[b*MW +: MW] = mdl[int'(s)*NB + b];
      exp_vld = v;
      if (we) mdl[ad] = d;
      #1;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; wr_en_i = 1'b0; smp_vld_i = 1'b0;
      @(posedge clk); @(posedge clk); #1;
      for (int i = 0; i < NS*NB; i++) mdl[i] = '0;
      exp_bm = '0; exp_vld = 1'b0;
      check("R1 in reset", bm_o, '0, bm_vld_o, 1'b0);
      @(negedge clk); rst_n = 1'b1;
      @(posedge clk); #1;
      check("R1 after release", bm_o, '0, bm_vld_o, 1'b0);
   endtask

   initial begin
      rst_n = 1'b0; smp_i = '0; smp_vld_i = 1'b0;
      wr_en_i = 1'b0; wr_addr_i = '0; wr_data_i = '0;
      exp_bm = '0; exp_vld = 1'b0;
      do_reset();

      // R2: every row reads zero before any write
      for (int s = 0; s < NS; s++) begin
         step(1'b0, 6'd0, '0, 1'b1, SW'(s));
         check("R2 zero after reset", bm_o, exp_bm, bm_vld_o, exp_vld);
      end

      // R3: load every entry through the write port
      for (int s = 0; s < NS; s++)
         for (int b = 0; b < NB; b++)
            step(1'b1, 6'((s << 3) | b), fill(s, b), 1'b0, '0);
      for (int s = 0; s < NS; s++) begin
         step(1'b0, 6'd0, '0, 1'b1, SW'(s));
         check("R3 loaded row", bm_o, exp_bm, bm_vld_o, exp_vld);
      end

      // R5: branch {prev=2'b10, bit=1} = 5 sits in lane 5 of sample 2
      step(1'b0, 6'd0, '0, 1'b1, 3'd2);
      n_run++;
      if (bm_o[5*MW +: MW] !== fill(2, 5)) begin
         n_fail++;
         $display("FAIL R5 lane 5: got %h expected %h", bm_o[5*MW +: MW], fill(2, 5));
      end

      // R4 R6 R7 R8 R9: vector table walk
      for (int i = 0; i < NV; i++) begin
         step(VEC[i][16], VEC[i][15:10], VEC[i][9:4], VEC[i][3], VEC[i][2:0]);
         check($sformatf("R4/R6/R7/R8/R9 vector %0d", i), bm_o, exp_bm, bm_vld_o, exp_vld);
      end

      // R7: idle cycle keeps metrics and drops valid
      step(1'b0, 6'd0, '0, 1'b0, 3'd5);
      check("R7 idle hold", bm_o, exp_bm, bm_vld_o, 1'b0);

      // R1 R2: reset mid-run clears the table
      do_reset();
      step(1'b0, 6'd0, '0, 1'b1, 3'd3);
      check("R2 cleared by reset", bm_o, '0, bm_vld_o, 1'b1);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #2000000;
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule